// File: doc/BRIEF.md
# Masked Chip-Select Window Decoder

This block sits between an internal bus master and a set of external or on-chip targets. It holds a small bank of programmable address windows. Each window has a 16-bit base value, a 16-bit per-bit don't-care mask, an enable flag and a read-only attribute. On every access strobe the upper half of the bus address is compared against all windows in parallel. The block then returns, one cycle later, exactly one of three results: a one-hot select for the winning window, a no-match flag, or a protection-violation flag.

Configuration is written through a plain register write port. The port names a window and chooses between its base word and its mask word. The decoder does not handle bus timing, data steering or pin multiplexing. The no-match and violation flags are meant to drive an error response further upstream.

Top module: `cs_window_decoder`

## Requirements
- R1: After reset every configuration field is zero, so every window is disabled. All three outputs are low, and the first access after reset reports no-match.
- R2: The decode uses only address bits 31..16. Bits 15..0 never change the result. A window matches when every unmasked address bit equals the base value. The base value is loaded from bits 31..16 of a base-word write (`cfg_is_mask`=0).
- R3: The mask is loaded from bits 31..16 of a mask-word write (`cfg_is_mask`=1). A mask bit of 1 makes the corresponding address bit a don't care, and a 0 requires that bit to equal the base.
- R4: The enable flag is bit 0 of the mask word. A window whose enable flag is 0 never matches, whatever its base and mask.
- R5: When several enabled windows match, only the lowest-numbered one is selected. `cs_sel` is one-hot, with bit i standing for window i.
- R6: The read-only flag is bit 8 of the mask word. A write (`acc_write`=1) whose winning window has this flag set drives `prot_err` high for one cycle and asserts no select. A read of that window completes normally.
- R7: An access that matches no enabled window drives `miss` high for one cycle and asserts no select.
- R8: Results are registered. They appear in the cycle after the strobe, last exactly one cycle, and exactly one of {`cs_sel` nonzero, `miss`, `prot_err`} is active per access. With no strobe, all outputs are low.
- R9: A configuration write affects accesses strobed from the following cycle on. An access strobed in the same cycle as the write is decoded with the old configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_win | input | IDX_W (3) | Window index of the configuration write |
| cfg_is_mask | input | 1 | 0 selects the base word, 1 selects the mask word |
| cfg_wdata | input | 32 | Configuration write data |
| acc_valid | input | 1 | Access strobe |
| acc_addr | input | ADDR_W (32) | Access address |
| acc_write | input | 1 | 1 for a write access, 0 for a read access |
| cs_sel | output | NUM_WIN (6) | One-hot window select, registered |
| miss | output | 1 | No enabled window matched, registered pulse |
| prot_err | output | 1 | Write to a read-only window was refused, registered pulse |

## Verification
The bench builds the decoder with its defaults: six windows and a 32-bit address. With six windows it can hold windows that overlap, so priority is visible. It also leaves one spare window for a catch-all mask (all ones), which separates "highest index wins by default" from "no match".

Window 0 and window 1 share a base but have masks of different width. Window 3 is read-only and sits below the catch-all, so a refused write cannot fall through to a higher window unnoticed. A configuration write issued in the same cycle as an access exposes the old-versus-new ordering of the configuration update.

// File: rtl/cs_dec_pkg.sv
package cs_dec_pkg;

    // width of the compared upper address slice and the config fields
    localparam int unsigned CMP_W     = 16;
    localparam int unsigned FIELD_LSB = 16;
    localparam int unsigned EN_BIT    = 0;
    localparam int unsigned RO_BIT    = 8;

    typedef struct packed {
        logic [CMP_W-1:0] base;
        logic [CMP_W-1:0] mask;
        logic             en;
        logic             ro;
    } win_cfg_t;

endpackage

// File: rtl/cs_cfg_bank.sv
module cs_cfg_bank
    import cs_dec_pkg::*;
#(
    parameter int unsigned NUM_WIN = 6,
    parameter int unsigned DATA_W  = 32,
    localparam int unsigned IDX_W  = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we,
    input  logic [IDX_W-1:0]           idx,
    input  logic                       is_mask,
    input  logic [DATA_W-1:0]          wdata,
    output win_cfg_t [NUM_WIN-1:0]     cfg_o
);

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        win_cfg_t cfg_d;
        win_cfg_t cfg_q;

        always_comb begin
            cfg_d = cfg_q;
            if (we && (idx == IDX_W'(w))) begin
                if (is_mask) begin
                    cfg_d.mask = wdata[FIELD_LSB +: CMP_W];
                    cfg_d.en   = wdata[EN_BIT];
                    cfg_d.ro   = wdata[RO_BIT];
                end else begin
                    cfg_d.base = wdata[FIELD_LSB +: CMP_W];
                end
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cfg_q <= '0;
            end else begin
                cfg_q <= cfg_d;
            end
        end

        assign cfg_o[w] = cfg_q;
    end

endmodule

// File: rtl/cs_win_match.sv
module cs_win_match
    import cs_dec_pkg::*;
(
    input  win_cfg_t         cfg,
    input  logic [CMP_W-1:0] addr_hi,
    output logic             hit
);

    logic [CMP_W-1:0] diff;

    always_comb begin
        diff = (addr_hi ^ cfg.base) & ~cfg.mask;
        hit  = cfg.en && (diff == '0);
    end

endmodule

// File: rtl/cs_prio_pick.sv
module cs_prio_pick #(
    parameter int unsigned N = 6
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt,
    output logic         any
);

    always_comb begin
        logic taken;
        taken = 1'b0;
        gnt   = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && !taken) begin
                gnt[i] = 1'b1;
                taken  = 1'b1;
            end
        end
        any = taken;
    end

endmodule

// File: rtl/cs_window_decoder.sv
module cs_window_decoder
    import cs_dec_pkg::*;
#(
    parameter int unsigned NUM_WIN = 6,
    parameter int unsigned ADDR_W  = 32,
    localparam int unsigned IDX_W  = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [IDX_W-1:0]   cfg_win,
    input  logic               cfg_is_mask,
    input  logic [31:0]        cfg_wdata,
    input  logic               acc_valid,
    input  logic [ADDR_W-1:0]  acc_addr,
    input  logic               acc_write,
    output logic [NUM_WIN-1:0] cs_sel,
    output logic               miss,
    output logic               prot_err
);

    typedef struct packed {
        logic [NUM_WIN-1:0] sel;
        logic               miss;
        logic               prot;
    } res_t;

    win_cfg_t [NUM_WIN-1:0] cfg;
    logic     [NUM_WIN-1:0] hit_vec;
    logic     [NUM_WIN-1:0] ro_vec;
    logic     [NUM_WIN-1:0] gnt;
    logic                   any_hit;
    logic     [CMP_W-1:0]   addr_hi;
    res_t                   res_d;
    res_t                   res_q;

    assign addr_hi = acc_addr[ADDR_W-1 -: CMP_W];

    cs_cfg_bank #(
        .NUM_WIN (NUM_WIN),
        .DATA_W  (32)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (cfg_we),
        .idx     (cfg_win),
        .is_mask (cfg_is_mask),
        .wdata   (cfg_wdata),
        .cfg_o   (cfg)
    );

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_cmp
        cs_win_match u_match (
            .cfg     (cfg[w]),
            .addr_hi (addr_hi),
            .hit     (hit_vec[w])
        );
        assign ro_vec[w] = cfg[w].ro;
    end

    cs_prio_pick #(
        .N (NUM_WIN)
    ) u_pick (
        .req (hit_vec),
        .gnt (gnt),
        .any (any_hit)
    );

    always_comb begin
        res_d = '0;
        if (acc_valid) begin
            if (!any_hit) begin
                res_d.miss = 1'b1;
            end else if (acc_write && ((gnt & ro_vec) != '0)) begin
                res_d.prot = 1'b1;
            end else begin
                res_d.sel = gnt;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign cs_sel   = res_q.sel;
    assign miss     = res_q.miss;
    assign prot_err = res_q.prot;

endmodule

// File: rtl/cs_window_decoder_chk.sv
module cs_window_decoder_chk #(
    parameter int unsigned NUM_WIN = 6
) (
    input logic               clk,
    input logic               rst_n,
    input logic               acc_valid,
    input logic               acc_write,
    input logic [NUM_WIN-1:0] cs_sel,
    input logic               miss,
    input logic               prot_err
);

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> (cs_sel == '0 && !miss && !prot_err));

    // R8
    one_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> ($countones({cs_sel, miss, prot_err}) == 1));

    // R5
    sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cs_sel));

    // R6
    read_no_prot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_write) |=> !prot_err);

endmodule

bind cs_window_decoder cs_window_decoder_chk #(.NUM_WIN(NUM_WIN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .cs_sel    (cs_sel),
    .miss      (miss),
    .prot_err  (prot_err)
);

// File: tb/sim_cs_window_decoder.sv
module sim_cs_window_decoder;

    localparam int  PERIOD  = 10;
    localparam int  NW      = 6;
    localparam int  IW      = 3;

    typedef struct packed {
        logic [NW-1:0] sel;
        logic          miss;
        logic          prot;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [IW-1:0] cfg_win = '0;
    logic          cfg_is_mask = 1'b0;
    logic [31:0]   cfg_wdata = '0;
    logic          acc_valid = 1'b0;
    logic [31:0]   acc_addr = '0;
    logic          acc_write = 1'b0;
    logic [NW-1:0] cs_sel;
    logic          miss;
    logic          prot_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    exp_t  exp_q[$];
    string tag_q[$];

    // bench-side model of the configuration
    logic [15:0] m_base [NW];
    logic [15:0] m_mask [NW];
    logic        m_en   [NW];
    logic        m_ro   [NW];

    bit          pend = 1'b0;
    int          pend_win;
    bit          pend_is_mask;
    logic [31:0] pend_data;

    always #(PERIOD/2) clk = ~clk;

    cs_window_decoder u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_we      (cfg_we),
        .cfg_win     (cfg_win),
        .cfg_is_mask (cfg_is_mask),
        .cfg_wdata   (cfg_wdata),
        .acc_valid   (acc_valid),
        .acc_addr    (acc_addr),
        .acc_write   (acc_write),
        .cs_sel      (cs_sel),
        .miss        (miss),
        .prot_err    (prot_err)
    );

    function automatic logic [31:0] mask_word(logic [15:0] m, logic ro, logic en);
        return {m, 7'd0, ro, 7'd0, en};
    endfunction

    function automatic exp_t predict(logic [31:0] a, logic wr);
        exp_t r;
        r = '0;
        for (int w = 0; w < NW; w++) begin
            if (m_en[w] && (((a[31:16] ^ m_base[w]) & ~m_mask[w]) == 16'h0)) begin
                if (wr && m_ro[w]) r.prot = 1'b1;
                else               r.sel[w] = 1'b1;
                return r;
            end
        end
        r.miss = 1'b1;
        return r;
    endfunction

    task automatic compare(exp_t e, string tag);
        checks++;
        if ({cs_sel, miss, prot_err} !== e) begin
            fails++;
            $display("FAIL %s: got sel=%b miss=%b prot=%b, expected sel=%b miss=%b prot=%b",
                     tag, cs_sel, miss, prot_err, e.sel, e.miss, e.prot);
        end
    endtask

    task automatic drive_access(logic [31:0] a, logic wr, string tag);
        exp_q.push_back(predict(a, wr));
        tag_q.push_back(tag);
        acc_valid = 1'b1;
        acc_addr  = a;
        acc_write = wr;
    endtask

    task automatic drive_cfg(int w, bit is_mask, logic [31:0] d);
        cfg_we       = 1'b1;
        cfg_win      = IW'(w);
        cfg_is_mask  = is_mask;
        cfg_wdata    = d;
        pend         = 1'b1;
        pend_win     = w;
        pend_is_mask = is_mask;
        pend_data    = d;
    endtask

    task automatic step();
        @(posedge clk);
        if (pend) begin
            if (pend_is_mask) begin
                m_mask[pend_win] = pend_data[31:16];
                m_en[pend_win]   = pend_data[0];
                m_ro[pend_win]   = pend_data[8];
            end else begin
                m_base[pend_win] = pend_data[31:16];
            end
            pend = 1'b0;
        end
        @(negedge clk);
        acc_valid = 1'b0;
        cfg_we    = 1'b0;
    endtask

    // monitor: pops an expected item for every strobed cycle
    initial begin
        @(posedge rst_n);
        forever begin
            bit   strobed;
            exp_t e;
            @(posedge clk);
            strobed = acc_valid;
            #(PERIOD/4);
            if (strobed) begin
                if (exp_q.size() == 0) begin
                    checks++;
                    fails++;
                    $display("FAIL R8: result slot with no expected item, got sel=%b miss=%b prot=%b, expected none",
                             cs_sel, miss, prot_err);
                end else begin
                    e = exp_q.pop_front();
                    compare(e, tag_q.pop_front());
                end
            end else begin
                compare('0, "R8 idle outputs low");
            end
        end
    end

    initial begin
        for (int w = 0; w < NW; w++) begin
            m_base[w] = '0; m_mask[w] = '0; m_en[w] = 1'b0; m_ro[w] = 1'b0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        compare('0, "R1 reset outputs low");

        // R1: all windows disabled after reset
        drive_access(32'h0000_0000, 1'b0, "R1 read after reset misses"); step();
        drive_access(32'h1234_5678, 1'b1, "R1 write after reset misses"); step();

        // window 0: base 0x1000, low 4 bits don't care
        drive_cfg(0, 1'b0, 32'h1000_0000); step();
        drive_cfg(0, 1'b1, mask_word(16'h000F, 1'b0, 1'b1)); step();
        drive_access(32'h1003_ABCD, 1'b0, "R3 masked bits ignored"); step();
        drive_access(32'h1000_FFFF, 1'b0, "R2 low half ignored"); step();
        drive_access(32'h1010_0000, 1'b0, "R2 unmasked bit differs -> miss"); step();
        drive_access(32'h9000_0000, 1'b0, "R7 no window -> miss"); step();

        // window 2 configured but disabled
        drive_cfg(2, 1'b0, 32'h2000_0000); step();
        drive_cfg(2, 1'b1, mask_word(16'h0000, 1'b0, 1'b0)); step();
        drive_access(32'h2000_0000, 1'b0, "R4 disabled window never matches"); step();
        drive_cfg(2, 1'b1, mask_word(16'h0000, 1'b0, 1'b1)); step();
        drive_access(32'h2000_0000, 1'b0, "R4 enabled window matches"); step();

        // overlapping windows: window 1 wider than window 0
        drive_cfg(1, 1'b0, 32'h1000_0000); step();
        drive_cfg(1, 1'b1, mask_word(16'h00FF, 1'b0, 1'b1)); step();
        drive_access(32'h1005_0000, 1'b0, "R5 lowest index wins"); step();
        drive_access(32'h1050_0000, 1'b0, "R5 only wider window"); step();
        drive_cfg(5, 1'b1, mask_word(16'hFFFF, 1'b0, 1'b1)); step();
        drive_access(32'h9999_0000, 1'b0, "R5 catch-all window"); step();
        drive_access(32'h1001_0000, 1'b1, "R5 lowest wins over catch-all"); step();

        // read-only window 3
        drive_cfg(3, 1'b0, 32'h3000_0000); step();
        drive_cfg(3, 1'b1, mask_word(16'h0000, 1'b1, 1'b1)); step();
        drive_access(32'h3000_0040, 1'b0, "R6 read of read-only window"); step();
        drive_access(32'h3000_0040, 1'b1, "R6 write refused"); step();
        drive_access(32'h1000_0000, 1'b1, "R6 write to writable window"); step();

        // back-to-back strobes without gaps
        drive_access(32'h3000_0000, 1'b1, "R8 back-to-back 1"); @(negedge clk);
        drive_access(32'h2000_0000, 1'b1, "R8 back-to-back 2"); @(negedge clk);
        drive_access(32'h3000_0000, 1'b0, "R8 back-to-back 3"); step();

        // same-cycle config write uses old configuration
        drive_cfg(3, 1'b1, mask_word(16'h0000, 1'b1, 1'b0));
        drive_access(32'h3000_0000, 1'b0, "R9 same-cycle access sees old config");
        step();
        drive_access(32'h3000_0000, 1'b0, "R9 next access sees new config"); step();

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            checks++;
            fails++;
            $display("FAIL R8: %0d results missing, expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(PERIOD * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule